// File: doc/BRIEF.md
# Dual-Mode I/Q Converter Data Port

This block sits between a pair of I/Q data converters and an external baseband processor. On the receive side it takes a sample pair (one I word and one Q word) from the converter core and sends the two words out one after the other on the shared transmit/receive bus. Each word carries an I/Q flag, and a qualifying clock toggles once per word. On the transmit side it collects single tagged words from the processor. It holds an I word until the matching Q word arrives, then hands both to the DAC side in the same cycle. A Q word that has no I word before it raises an error pulse.

A static mode input selects full-duplex or half-duplex operation. In full-duplex, transmit words arrive on a dedicated bus, the shared bus always carries receive data, and a dual-function pin gives the I/Q flag of each transmit word. In half-duplex, the dedicated bus is ignored and the same pin sets the direction of the shared bus. Its output enable is released one full clock before any input word is captured. A separate qualifying clock for the transmit bus can be driven by the block or left undriven. The block is one clock domain with a synchronous active-high reset, and every output is registered.

Top module: `iq_port_top`

## Requirements
- R1: While `rst` is high, each clock edge sets `trx_oe`=0 (shared bus is an input), `trx_iq_o`=1 (I), and `trx_dout`, `rx_qclk`, `dac_valid`, `pair_err`, `tx_qclk_o` and `tx_qclk_oe` to 0. It also discards any held I word and any pending Q word.
- R2: A receive pair offered with `rx_valid` at an edge, when no Q word is pending, gives `trx_dout`=`rx_i` with `trx_iq_o`=1 after that edge. After the next edge it gives `trx_dout`=`rx_q` with `trx_iq_o`=0. `rx_qclk` toggles on each of these two edges and on no other.
- R3: A receive pair offered at the edge where the Q word of the previous pair is sent is dropped. Only the previous Q word appears, and no extra toggle of `rx_qclk` occurs for the dropped pair.
- R4: In full-duplex (`half_duplex`=0), a transmit word is taken from `tx_d` on every edge with `tx_wen`=1. Its flag is `txiq_txnrx` (1 = I, 0 = Q). `trx_din` and `trx_iq_i` have no effect, and `trx_oe` is 1 from the first edge after reset.
- R5: An accepted I word is held; a later accepted I word replaces it. The next accepted Q word makes `dac_valid`=1 for one cycle after that edge, with `dac_i` = the held I word and `dac_q` = the Q word. The held I word is then consumed.
- R6: An accepted Q word with no held I word gives `pair_err`=1 for one cycle after that edge, and `dac_valid` stays 0.
- R7: In half-duplex, at each edge `trx_oe` becomes the inverse of `txiq_txnrx`. A word is taken from `trx_din`, with its flag from `trx_iq_i`, only at an edge where `tx_wen`=1, `txiq_txnrx`=1 and `trx_oe` is already 0. `tx_d` has no effect.
- R8: In half-duplex, a word offered at the first edge after `txiq_txnrx` rises (while `trx_oe` is still 1) is dropped.
- R9: At an edge where `half_duplex` differs from its value at the previous edge, the held I word and any pending receive Q word are discarded. Transmit and receive inputs offered at that edge are ignored.
- R10: After each edge `tx_qclk_oe` equals `tx_clk_drive`. `tx_qclk_o` toggles on every edge while `tx_clk_drive` is 1 and is 0 while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| half_duplex | input | 1 | Static mode: 0 full-duplex, 1 half-duplex |
| tx_clk_drive | input | 1 | 1 = block drives the transmit-bus qualifying clock |
| rx_valid | input | 1 | Receive sample pair offered |
| rx_i | input | 12 | Receive I sample |
| rx_q | input | 12 | Receive Q sample |
| tx_d | input | 12 | Dedicated transmit bus (full-duplex) |
| txiq_txnrx | input | 1 | I/Q flag (full-duplex) or TX-not-RX direction (half-duplex) |
| tx_wen | input | 1 | Transmit word present |
| trx_din | input | 12 | Shared bus input side |
| trx_iq_i | input | 1 | I/Q flag of an input word on the shared bus |
| trx_dout | output | 12 | Shared bus output side |
| trx_oe | output | 1 | Shared bus output enable |
| trx_iq_o | output | 1 | I/Q flag of the outgoing receive word (1 = I) |
| rx_qclk | output | 1 | Receive qualifying clock, toggles per word |
| tx_qclk_o | output | 1 | Transmit-bus qualifying clock when driven |
| tx_qclk_oe | output | 1 | Output enable of the transmit-bus clock |
| dac_i | output | 12 | Paired I sample to the DAC side |
| dac_q | output | 12 | Paired Q sample to the DAC side |
| dac_valid | output | 1 | Pair valid, one cycle |
| pair_err | output | 1 | Q word arrived without an I word |

## Verification
In half-duplex, a direction reversal and the arrival of a transmit word can fall in the same cycle: the pin rises at the very edge that offers a word. The bench provokes this on purpose and at random. It judges the result by the pairing outputs: the dropped I word must make the next Q word raise `pair_err` rather than `dac_valid`. A mode change can also coincide with a Q word or a receive pair. The bench checks that neither is accepted, and that a Q word after the change is reported as unpaired.

// File: rtl/iq_port_pkg.sv
package iq_port_pkg;
  localparam int unsigned SAMPLE_W_DEF = 12;

  typedef enum logic {
    DUPLEX_FULL = 1'b0,
    DUPLEX_HALF = 1'b1
  } duplex_e;
endpackage

// File: rtl/iq_rx_serializer.sv
module iq_rx_serializer #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         in_valid,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] in_q,
  output logic [W-1:0] word_o,
  output logic         iq_o,
  output logic         qclk_o
);
  logic [W-1:0] held_q;
  logic         q_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
      iq_o   <= 1'b1;
      qclk_o <= 1'b0;
      held_q <= '0;
      q_pend <= 1'b0;
    end else if (flush) begin
      q_pend <= 1'b0;
    end else if (q_pend) begin
      word_o <= held_q;
      iq_o   <= 1'b0;
      qclk_o <= ~qclk_o;
      q_pend <= 1'b0;
    end else if (in_valid) begin
      word_o <= in_i;
      iq_o   <= 1'b1;
      held_q <= in_q;
      qclk_o <= ~qclk_o;
      q_pend <= 1'b1;
    end
  end

  // R2
  q_word_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (q_pend && !flush) |=> (!iq_o && $changed(qclk_o)));

  // R3
  no_pair_during_q_chk: assert property (@(posedge clk) disable iff (rst)
    (q_pend && in_valid && !flush) |=> !q_pend);
endmodule

// File: rtl/iq_tx_pairer.sv
module iq_tx_pairer #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         wen,
  input  logic         is_i,
  input  logic [W-1:0] word,
  output logic [W-1:0] pair_i_o,
  output logic [W-1:0] pair_q_o,
  output logic         pair_valid_o,
  output logic         orphan_o
);
  logic [W-1:0] held_i;
  logic         have_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_i       <= '0;
      have_i       <= 1'b0;
      pair_i_o     <= '0;
      pair_q_o     <= '0;
      pair_valid_o <= 1'b0;
      orphan_o     <= 1'b0;
    end else begin
      pair_valid_o <= 1'b0;
      orphan_o     <= 1'b0;
      if (flush) begin
        have_i <= 1'b0;
      end else if (wen) begin
        if (is_i) begin
          held_i <= word;
          have_i <= 1'b1;
        end else if (have_i) begin
          pair_i_o     <= held_i;
          pair_q_o     <= word;
          pair_valid_o <= 1'b1;
          have_i       <= 1'b0;
        end else begin
          orphan_o <= 1'b1;
        end
      end
    end
  end

  // R6
  orphan_not_valid_chk: assert property (@(posedge clk) disable iff (rst)
    orphan_o |-> !pair_valid_o);

  // R5
  pair_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    pair_valid_o |=> !pair_valid_o);
endmodule

// File: rtl/iq_bus_dir.sv
module iq_bus_dir (
  input  logic clk,
  input  logic rst,
  input  logic half_mode,
  input  logic dir_pin,
  input  logic clk_drive,
  output logic bus_oe_o,
  output logic cap_ok_o,
  output logic tqclk_o,
  output logic tqclk_oe_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe_o   <= 1'b0;
      tqclk_o    <= 1'b0;
      tqclk_oe_o <= 1'b0;
    end else begin
      bus_oe_o   <= half_mode ? ~dir_pin : 1'b1;
      tqclk_oe_o <= clk_drive;
      tqclk_o    <= clk_drive ? ~tqclk_o : 1'b0;
    end
  end

  // capture only once the output driver has been off for a full clock
  assign cap_ok_o = half_mode & dir_pin & ~bus_oe_o;

  // R10
  tqclk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !tqclk_oe_o |-> !tqclk_o);
endmodule

// File: rtl/iq_port_top.sv
module iq_port_top
  import iq_port_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         half_duplex,
  input  logic         tx_clk_drive,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_i,
  input  logic [W-1:0] rx_q,
  input  logic [W-1:0] tx_d,
  input  logic         txiq_txnrx,
  input  logic         tx_wen,
  input  logic [W-1:0] trx_din,
  input  logic         trx_iq_i,
  output logic [W-1:0] trx_dout,
  output logic         trx_oe,
  output logic         trx_iq_o,
  output logic         rx_qclk,
  output logic         tx_qclk_o,
  output logic         tx_qclk_oe,
  output logic [W-1:0] dac_i,
  output logic [W-1:0] dac_q,
  output logic         dac_valid,
  output logic         pair_err
);
  duplex_e      mode_q, mode_now;
  logic         mode_chg;
  logic         cap_ok;
  logic         word_wen;
  logic         word_is_i;
  logic [W-1:0] word_sel;

  assign mode_now = duplex_e'(half_duplex);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= mode_now;
    else     mode_q <= mode_now;
  end

  assign mode_chg = (mode_now != mode_q);

  always_comb begin
    if (mode_now == DUPLEX_HALF) begin
      word_sel  = trx_din;
      word_is_i = trx_iq_i;
      word_wen  = tx_wen & cap_ok & ~mode_chg;
    end else begin
      word_sel  = tx_d;
      word_is_i = txiq_txnrx;
      word_wen  = tx_wen & ~mode_chg;
    end
  end

  iq_bus_dir u_dir (
    .clk        (clk),
    .rst        (rst),
    .half_mode  (mode_now == DUPLEX_HALF),
    .dir_pin    (txiq_txnrx),
    .clk_drive  (tx_clk_drive),
    .bus_oe_o   (trx_oe),
    .cap_ok_o   (cap_ok),
    .tqclk_o    (tx_qclk_o),
    .tqclk_oe_o (tx_qclk_oe)
  );

  iq_rx_serializer #(.W(W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .flush    (mode_chg),
    .in_valid (rx_valid),
    .in_i     (rx_i),
    .in_q     (rx_q),
    .word_o   (trx_dout),
    .iq_o     (trx_iq_o),
    .qclk_o   (rx_qclk)
  );

  iq_tx_pairer #(.W(W)) u_tx (
    .clk          (clk),
    .rst          (rst),
    .flush        (mode_chg),
    .wen          (word_wen),
    .is_i         (word_is_i),
    .word         (word_sel),
    .pair_i_o     (dac_i),
    .pair_q_o     (dac_q),
    .pair_valid_o (dac_valid),
    .orphan_o     (pair_err)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!trx_oe && trx_iq_o && !dac_valid && !pair_err && !tx_qclk_oe));

  // R7
  turnaround_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (half_duplex && txiq_txnrx) |=> !trx_oe);

  // R4
  full_drives_chk: assert property (@(posedge clk) disable iff (rst)
    !half_duplex |=> trx_oe);

  // R9
  mode_flush_chk: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (!dac_valid && !pair_err));
endmodule

// File: tb/iq_port_top_tb_top.sv
module iq_port_top_tb_top;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic half_duplex = 1'b0, tx_clk_drive = 1'b0, rx_valid = 1'b0;
  logic [W-1:0] rx_i = '0, rx_q = '0, tx_d = '0, trx_din = '0;
  logic txiq_txnrx = 1'b0, tx_wen = 1'b0, trx_iq_i = 1'b0;
  logic [W-1:0] trx_dout, dac_i, dac_q;
  logic trx_oe, trx_iq_o, rx_qclk, tx_qclk_o, tx_qclk_oe, dac_valid, pair_err;

  int total = 0, bad = 0;
  bit done = 1'b0;
  string tag = "R1";

  // model state
  logic m_mode, m_oe, m_have, m_pend, m_iq, m_qclk, m_tq, m_tqoe, m_valid, m_err;
  logic [W-1:0] m_hold, m_hq, m_dout, m_di, m_dq;

  always #5 clk = ~clk;

  iq_port_top #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .half_duplex(half_duplex), .tx_clk_drive(tx_clk_drive),
    .rx_valid(rx_valid), .rx_i(rx_i), .rx_q(rx_q), .tx_d(tx_d),
    .txiq_txnrx(txiq_txnrx), .tx_wen(tx_wen), .trx_din(trx_din), .trx_iq_i(trx_iq_i),
    .trx_dout(trx_dout), .trx_oe(trx_oe), .trx_iq_o(trx_iq_o), .rx_qclk(rx_qclk),
    .tx_qclk_o(tx_qclk_o), .tx_qclk_oe(tx_qclk_oe), .dac_i(dac_i), .dac_q(dac_q),
    .dac_valid(dac_valid), .pair_err(pair_err)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL [%s/%s] %s actual=%0h expected=%0h", tag, req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = half_duplex; m_oe = 0; m_have = 0; m_pend = 0; m_iq = 1; m_qclk = 0;
    m_tq = 0; m_tqoe = 0; m_valid = 0; m_err = 0; m_dout = '0; m_di = '0; m_dq = '0;
    m_hold = '0; m_hq = '0;
  endtask

  // expected behaviour of one clock edge, taken from the requirements
  task automatic model_edge();
    logic chg, cap, acc, fl;
    logic [W-1:0] w;
    chg = (half_duplex != m_mode);
    m_mode = half_duplex;
    cap = half_duplex & txiq_txnrx & ~m_oe;
    acc = !chg && tx_wen && (half_duplex ? cap : 1'b1);
    w  = half_duplex ? trx_din : tx_d;
    fl = half_duplex ? trx_iq_i : txiq_txnrx;
    m_valid = 0; m_err = 0;
    if (chg) m_have = 0;
    else if (acc) begin
      if (fl) begin m_hold = w; m_have = 1; end
      else if (m_have) begin m_di = m_hold; m_dq = w; m_valid = 1; m_have = 0; end
      else m_err = 1;
    end
    if (chg) m_pend = 0;
    else if (m_pend) begin m_dout = m_hq; m_iq = 0; m_qclk = ~m_qclk; m_pend = 0; end
    else if (rx_valid) begin m_dout = rx_i; m_iq = 1; m_hq = rx_q; m_qclk = ~m_qclk; m_pend = 1; end
    m_oe = half_duplex ? ~txiq_txnrx : 1'b1;
    m_tqoe = tx_clk_drive;
    m_tq = tx_clk_drive ? ~m_tq : 1'b0;
  endtask

  task automatic step();
    model_edge();
    @(posedge clk); #1;
    chk("R5", "dac_valid", dac_valid, m_valid);
    if (m_valid) begin
      chk("R5", "dac_i", dac_i, m_di);
      chk("R5", "dac_q", dac_q, m_dq);
    end
    chk("R6", "pair_err", pair_err, m_err);
    chk("R7", "trx_oe", trx_oe, m_oe);
    chk("R2", "trx_dout", trx_dout, m_dout);
    chk("R2", "trx_iq_o", trx_iq_o, m_iq);
    chk("R2", "rx_qclk", rx_qclk, m_qclk);
    chk("R10", "tx_qclk_o", tx_qclk_o, m_tq);
    chk("R10", "tx_qclk_oe", tx_qclk_oe, m_tqoe);
  endtask

  task automatic tx_word(logic flag, logic [W-1:0] d);
    tx_wen = 1; txiq_txnrx = flag; tx_d = d; step(); tx_wen = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL [watchdog] run hung actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "trx_oe", trx_oe, 0);
    chk("R1", "trx_iq_o", trx_iq_o, 1);
    chk("R1", "dac_valid", dac_valid, 0);
    chk("R1", "pair_err", pair_err, 0);
    chk("R1", "tx_qclk_oe", tx_qclk_oe, 0);
    chk("R1", "rx_qclk", rx_qclk, 0);
    rst = 0;
    model_reset();
    step();

    tag = "R5"; tx_word(1, 12'h123); tx_word(0, 12'h456); step();
    tag = "R5"; tx_word(1, 12'haaa); tx_word(1, 12'hbbb); tx_word(0, 12'hccc); step();
    tag = "R6"; tx_word(0, 12'h777); step();
    tag = "R4"; trx_din = 12'hfff; trx_iq_i = 1; tx_word(1, 12'h010);
    trx_iq_i = 0; tx_word(0, 12'h020); step();
    tag = "R3"; rx_valid = 1; rx_i = 12'h111; rx_q = 12'h222; step();
    rx_i = 12'h333; rx_q = 12'h444; step(); rx_valid = 0; step(); step();
    tag = "R9"; tx_word(1, 12'h555); half_duplex = 1; rx_valid = 1; step();
    rx_valid = 0; half_duplex = 0; step(); tx_word(0, 12'h666); step();
    tag = "R8"; half_duplex = 1; txiq_txnrx = 0; step(); step();
    trx_din = 12'h0a0; trx_iq_i = 1; tx_wen = 1; txiq_txnrx = 1; step();
    trx_din = 12'h0b0; trx_iq_i = 0; step(); tx_wen = 0; step();
    tag = "R7"; trx_din = 12'h0c0; trx_iq_i = 1; tx_wen = 1; tx_d = 12'hdea; step();
    trx_din = 12'h0d0; trx_iq_i = 0; step(); tx_wen = 0; txiq_txnrx = 0; step(); step();
    tag = "R10"; tx_clk_drive = 1; repeat (4) step(); tx_clk_drive = 0; step(); step();
    half_duplex = 0; step();

    tag = "RND";
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(99) == 0) half_duplex = ~half_duplex;
      tx_clk_drive = ($urandom_range(7) != 0) ? tx_clk_drive : ~tx_clk_drive;
      rx_valid = $urandom_range(1);
      rx_i = W'($urandom); rx_q = W'($urandom);
      tx_d = W'($urandom); trx_din = W'($urandom);
      trx_iq_i = $urandom_range(1);
      tx_wen = ($urandom_range(3) != 0);
      if (half_duplex) begin
        if ($urandom_range(5) == 0) txiq_txnrx = ~txiq_txnrx;
      end else begin
        txiq_txnrx = $urandom_range(1);
      end
      step();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule